// File: doc/BRIEF.md
# Infrared Pulse-Width Capture Receiver

This block sits behind a demodulated infrared input and times every symbol on the line. A symbol is one high (active) interval followed by one low (idle) interval. Both intervals are counted in units of ten base ticks. A base tick is one microsecond when the prescaler field holds the clock frequency in MHz minus one. Each finished symbol goes into a receive FIFO as one 32-bit word. A low interval that grows until active plus idle reaches a programmable maximum closes the frame, stores the last symbol and flags a timeout. Protocol decoding is left entirely to software.

Software talks to the block through a flat register port: an enable register, a busy register, a start register, a configuration word, a pending-count register, a data register that pops one word per read, an interrupt mask, a status register and a write-one-to-clear register. Three level interrupt outputs are driven: receive level reached, frame timeout and FIFO overflow. After an overflow the FIFO keeps its contents, and software drains it before clearing the flag.

Register byte offsets: enable 0x00, configuration 0x04, busy 0x08, start 0x0C, count 0x10, data 0x14, mask 0x18, status 0x1C, clear 0x20.

Top module: `ir_pulse_capture`

## Requirements
- R1: After reset: busy reads 0, count reads 0, status reads 0, the mask register reads 7, all interrupt outputs are low, and the configuration word reads 0x3E80_0080. That value is a maximum width of 0x3E80 in bits 31:16, format 0 in bits 15:14, level 0 in bits 13:8, raw mode 1 in bit 7 and prescaler 0 in bits 6:0.
- R2: A write with bit 0 set to the enable register makes busy read 1 for INIT_CYCLES clocks. It also empties the FIFO and clears all status flags. A start write is ignored while the block is disabled or busy. No symbol is captured until a start write has been accepted.
- R3: Each stored word holds the high duration in bits 15:0 and the following low duration in bits 31:16. Both are counted in units of 10 × (prescaler + 1) clocks and rounded down.
- R4: A symbol begins on a low-to-high change of the input. Low time before the first rising edge of a frame is not stored. A rising edge during the low interval stores the current symbol and starts the next one.
- R5: When high plus low units reach the maximum width (bits 31:16), the low count stops at maximum minus high. That symbol is stored, and the timeout flag is set.
- R6: The count register returns the number of stored words. Each read of the data register returns the oldest word and removes it. A data read while the FIFO is empty returns 0 and leaves the count at 0.
- R7: The receive flag is set when a store brings the count to level + 1 or more, where level is configuration bits 13:8.
- R8: While the FIFO holds FIFO_DEPTH words, new symbols are dropped and the overflow flag is set. The stored words stay intact and in order.
- R9: Status shows receive, timeout and overflow on bits 8, 9 and 10, and again on bits 24, 25 and 26. Writing 1 to clear-register bits 16, 17 and 18 clears them respectively. Writing 0 changes nothing.
- R10: Mask register bits 0, 1 and 2 belong to receive, timeout and overflow. Each interrupt output is high only while its flag is set and its mask bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ir_in | input | 1 | Demodulated infrared line, asynchronous |
| bus_addr | input | 6 | Register byte address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops on the data register) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| irq_rx | output | 1 | Receive-level interrupt |
| irq_tmo | output | 1 | Frame-timeout interrupt |
| irq_ovf | output | 1 | Overflow interrupt |

## Verification
Frames of random length are built from random high and low widths, each placed half a unit inside its bucket. Several prescaler settings are used, so the stored words show whether the unit length and the rounding follow the prescaler. Frames shorter and longer than the receive level tell a level-triggered flag apart from one raised on every store. Each frame ends in a timeout, which checks the clipped low count. A 70-symbol frame runs past the FIFO depth and shows that the first 64 words survive unchanged and in order. Pulses driven before the start register is accepted, and pulses driven after a start write made while busy, show that capture is gated.

// File: rtl/ir_cap_pkg.sv
// Package: register offsets, bit positions and shared types for the IR
// capture receiver. Assumes byte addressing on a 6-bit register port.
package ir_cap_pkg;

    localparam int ADDR_W = 6;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] A_ENABLE = 6'h00;
    localparam logic [ADDR_W-1:0] A_CONFIG = 6'h04;
    localparam logic [ADDR_W-1:0] A_BUSY   = 6'h08;
    localparam logic [ADDR_W-1:0] A_START  = 6'h0C;
    localparam logic [ADDR_W-1:0] A_COUNT  = 6'h10;
    localparam logic [ADDR_W-1:0] A_DATA   = 6'h14;
    localparam logic [ADDR_W-1:0] A_MASK   = 6'h18;
    localparam logic [ADDR_W-1:0] A_STATUS = 6'h1C;
    localparam logic [ADDR_W-1:0] A_CLEAR  = 6'h20;

    localparam int ST_LO_BASE  = 8;
    localparam int ST_HI_BASE  = 24;
    localparam int CLR_BASE    = 16;

    localparam logic [DATA_W-1:0] CFG_RESET = {16'h3E80, 2'b00, 6'd0, 1'b1, 7'd0};

    typedef enum logic [1:0] {
        MS_WAIT = 2'd0,
        MS_MARK = 2'd1,
        MS_GAP  = 2'd2
    } meas_state_e;

    typedef struct packed {
        logic [15:0] gap;
        logic [15:0] mark;
    } symbol_t;

endpackage

// File: rtl/ir_cap_sync.sv
// Synchroniser and edge detector for the asynchronous IR line.
// Assumes STAGES >= 2; rise/fall are one-cycle pulses on the synced level.
module ir_cap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] chain;

    // Shift the raw line through the synchroniser plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-1:0], din};
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];
    assign fall = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/ir_cap_tick.sv
// Time base: divides the clock by (presc + 1) into base ticks and emits
// one unit pulse every UNIT_TICKS base ticks. Restart zeroes the phase.
module ir_cap_tick #(
    parameter int PRE_W      = 7,
    parameter int UNIT_TICKS = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [PRE_W-1:0] presc,
    output logic             unit_tick
);
    localparam int UW = (UNIT_TICKS > 1) ? $clog2(UNIT_TICKS) : 1;

    logic [PRE_W-1:0] pre_cnt;
    logic [UW-1:0]    sub_cnt;
    logic             base_tick;

    assign base_tick = (pre_cnt == presc);
    assign unit_tick = base_tick && (sub_cnt == UW'(UNIT_TICKS - 1));

    // Advance the prescaler and the sub-unit counter.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pre_cnt <= '0;
            sub_cnt <= '0;
        end else if (base_tick) begin
            pre_cnt <= '0;
            sub_cnt <= unit_tick ? '0 : sub_cnt + UW'(1);
        end else begin
            pre_cnt <= pre_cnt + PRE_W'(1);
        end
    end
endmodule

// File: rtl/ir_cap_measure.sv
// Symbol timer: measures high (mark) then low (gap) widths in units,
// saturating at all-ones. Stores a symbol on the next rising edge, or
// closes the frame when mark + gap reaches max_w. Held idle while !run.
module ir_cap_measure
    import ir_cap_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          rise,
    input  logic          fall,
    input  logic          unit_tick,
    input  logic [CW-1:0] max_w,
    output logic          restart,
    output logic          push,
    output logic          tmo,
    output symbol_t       sym
);
    meas_state_e   state;
    logic [CW-1:0] mark_cnt;
    logic [CW-1:0] gap_cnt;
    logic [CW:0]   span;
    logic          hit;

    assign span = {1'b0, mark_cnt} + {1'b0, gap_cnt};
    assign hit  = span >= {1'b0, max_w};
    assign sym  = '{gap: gap_cnt, mark: mark_cnt};

    // Decode the events of the current cycle.
    always_comb begin
        restart = 1'b0;
        push    = 1'b0;
        tmo     = 1'b0;
        if (run) begin
            unique case (state)
                MS_WAIT: restart = rise;
                MS_MARK: restart = fall;
                MS_GAP: begin
                    if (rise) begin
                        push    = 1'b1;
                        restart = 1'b1;
                    end else if (hit) begin
                        push = 1'b1;
                        tmo  = 1'b1;
                    end
                end
                default: restart = 1'b0;
            endcase
        end
    end

    // Walk the symbol phases and count units.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            state    <= MS_WAIT;
            mark_cnt <= '0;
            gap_cnt  <= '0;
        end else begin
            unique case (state)
                MS_WAIT: if (rise) begin
                    state    <= MS_MARK;
                    mark_cnt <= '0;
                    gap_cnt  <= '0;
                end
                MS_MARK: begin
                    if (fall) state <= MS_GAP;
                    else if (unit_tick && mark_cnt != '1) mark_cnt <= mark_cnt + CW'(1);
                end
                MS_GAP: begin
                    if (rise) begin
                        state    <= MS_MARK;
                        mark_cnt <= '0;
                        gap_cnt  <= '0;
                    end else if (hit) begin
                        state <= MS_WAIT;
                    end else if (unit_tick && gap_cnt != '1) begin
                        gap_cnt <= gap_cnt + CW'(1);
                    end
                end
                default: state <= MS_WAIT;
            endcase
        end
    end
endmodule

// File: rtl/ir_cap_fifo.sv
// Receive FIFO with a combinational head. Assumes DEPTH is a power of two.
// A push when full is dropped and a pop when empty is ignored.
module ir_cap_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata,
    output logic [$clog2(DEPTH):0] count,
    output logic             full,
    output logic             empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic             do_push;
    logic             do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + AW'(1);
            if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/ir_pulse_capture.sv
// Top: register port, init/busy/arm control, interrupt flags and masking
// around the synchroniser, time base, symbol timer and receive FIFO.
// Assumes single-cycle register strobes; reads are combinational.
module ir_pulse_capture
    import ir_cap_pkg::*;
#(
    parameter int FIFO_DEPTH  = 64,
    parameter int INIT_CYCLES = 8,
    parameter int UNIT_TICKS  = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ir_in,
    input  logic [5:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq_rx,
    output logic        irq_tmo,
    output logic        irq_ovf
);
    localparam int CNT_W = $clog2(FIFO_DEPTH) + 1;
    localparam int NW    = CNT_W + 1;
    localparam int TW    = (NW > 7) ? NW : 7;
    localparam int IW    = $clog2(INIT_CYCLES + 1);

    logic          enabled, armed, busy, flush, run;
    logic [IW-1:0] init_cnt;
    logic [31:0]   cfg;
    logic [2:0]    mask;
    logic          flag_rx, flag_tmo, flag_ovf;
    logic          rise, fall, unit_tick, restart;
    logic          meas_push, meas_tmo;
    symbol_t       meas_sym;
    logic [31:0]   fifo_rdata;
    logic [CNT_W-1:0] fifo_count;
    logic          fifo_full, fifo_empty;
    logic          pop_req, push_ok, pop_ok;
    logic [NW-1:0] new_count;
    logic [TW-1:0] lvl_thr;
    logic [2:0]    clr;
    logic          wr_enable, wr_start;

    assign wr_enable = bus_wr && (bus_addr == A_ENABLE);
    assign wr_start  = bus_wr && (bus_addr == A_START);
    assign flush     = wr_enable && bus_wdata[0];
    assign busy      = (init_cnt != '0);
    assign run       = armed && cfg[7] && !busy;
    assign pop_req   = bus_rd && (bus_addr == A_DATA);
    assign push_ok   = meas_push && !fifo_full;
    assign pop_ok    = pop_req && !fifo_empty;
    assign new_count = NW'(fifo_count) + NW'(push_ok) - NW'(pop_ok);
    assign lvl_thr   = TW'(cfg[13:8]) + TW'(1);
    assign clr       = (bus_wr && bus_addr == A_CLEAR) ? bus_wdata[CLR_BASE+2:CLR_BASE] : 3'b000;

    ir_cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(ir_in), .rise(rise), .fall(fall)
    );

    ir_cap_tick #(.PRE_W(7), .UNIT_TICKS(UNIT_TICKS)) u_tick (
        .clk(clk), .rst_n(rst_n), .restart(restart), .presc(cfg[6:0]),
        .unit_tick(unit_tick)
    );

    ir_cap_measure #(.CW(16)) u_meas (
        .clk(clk), .rst_n(rst_n), .run(run), .rise(rise), .fall(fall),
        .unit_tick(unit_tick), .max_w(cfg[31:16]), .restart(restart),
        .push(meas_push), .tmo(meas_tmo), .sym(meas_sym)
    );

    ir_cap_fifo #(.WIDTH(32), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(meas_push),
        .pop(pop_req), .wdata(meas_sym), .rdata(fifo_rdata),
        .count(fifo_count), .full(fifo_full), .empty(fifo_empty)
    );

    // Enable, initialisation countdown and capture arming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enabled  <= 1'b0;
            init_cnt <= '0;
            armed    <= 1'b0;
        end else if (wr_enable) begin
            enabled  <= bus_wdata[0];
            init_cnt <= bus_wdata[0] ? IW'(INIT_CYCLES) : '0;
            armed    <= 1'b0;
        end else begin
            if (busy) init_cnt <= init_cnt - IW'(1);
            if (wr_start && enabled && !busy) armed <= 1'b1;
        end
    end

    // Configuration and mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg  <= CFG_RESET;
            mask <= 3'b111;
        end else begin
            if (bus_wr && bus_addr == A_CONFIG) cfg  <= bus_wdata;
            if (bus_wr && bus_addr == A_MASK)   mask <= bus_wdata[2:0];
        end
    end

    // Sticky interrupt flags; a new event wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            flag_rx  <= 1'b0;
            flag_tmo <= 1'b0;
            flag_ovf <= 1'b0;
        end else begin
            flag_rx  <= (push_ok && (TW'(new_count) >= lvl_thr)) || (flag_rx && !clr[0]);
            flag_tmo <= meas_tmo || (flag_tmo && !clr[1]);
            flag_ovf <= (meas_push && fifo_full) || (flag_ovf && !clr[2]);
        end
    end

    assign irq_rx  = flag_rx  && !mask[0];
    assign irq_tmo = flag_tmo && !mask[1];
    assign irq_ovf = flag_ovf && !mask[2];

    // Register read multiplexer.
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_ENABLE: bus_rdata = {31'd0, enabled};
            A_CONFIG: bus_rdata = cfg;
            A_BUSY:   bus_rdata = {31'd0, busy};
            A_COUNT:  bus_rdata = 32'(fifo_count);
            A_DATA:   bus_rdata = fifo_empty ? 32'd0 : fifo_rdata;
            A_MASK:   bus_rdata = {29'd0, mask};
            A_STATUS: begin
                bus_rdata[ST_LO_BASE+:3] = {flag_ovf, flag_tmo, flag_rx};
                bus_rdata[ST_HI_BASE+:3] = {flag_ovf, flag_tmo, flag_rx};
            end
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/ir_cap_checker.sv
// Checker: temporal properties over the capture receiver's control,
// flag and FIFO state. Attached to every ir_pulse_capture by bind.
module ir_cap_checker
    import ir_cap_pkg::*;
#(
    parameter int FIFO_DEPTH = 64
) (
    input logic clk,
    input logic rst_n,
    input logic bus_wr,
    input logic bus_rd,
    input logic [5:0] bus_addr,
    input logic clr_tmo_bit,
    input logic armed,
    input logic enabled,
    input logic busy,
    input logic meas_push,
    input logic meas_tmo,
    input logic fifo_full,
    input logic [$clog2(FIFO_DEPTH):0] fifo_count,
    input logic flush,
    input logic flag_rx,
    input logic flag_tmo,
    input logic flag_ovf,
    input logic [((($clog2(FIFO_DEPTH)+2) > 7) ? ($clog2(FIFO_DEPTH)+2) : 7)-1:0] lvl_thr
);
    localparam int CNT_W = $clog2(FIFO_DEPTH) + 1;
    localparam int TW    = ((CNT_W + 1) > 7) ? (CNT_W + 1) : 7;

    logic pop_req;
    assign pop_req = bus_rd && (bus_addr == A_DATA);

    AST_ARM_AFTER_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> ($past(enabled) && !$past(busy))); // R2

    AST_TMO_FROM_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_tmo) |-> $past(meas_push)); // R5

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CNT_W'(FIFO_DEPTH)); // R6

    AST_RX_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_rx) |-> (TW'(fifo_count) >= lvl_thr)); // R7

    AST_NO_OVERFLOW_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && !pop_req && !flush) |=> fifo_full); // R8

    AST_OVF_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_push && fifo_full && !flush) |=> flag_ovf); // R8

    AST_CLR_TMO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CLEAR && clr_tmo_bit && !meas_tmo) |=> !flag_tmo); // R9
endmodule

bind ir_pulse_capture ir_cap_checker #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .clr_tmo_bit(bus_wdata[17]), .armed(armed),
    .enabled(enabled), .busy(busy), .meas_push(meas_push),
    .meas_tmo(meas_tmo), .fifo_full(fifo_full), .fifo_count(fifo_count),
    .flush(flush), .flag_rx(flag_rx), .flag_tmo(flag_tmo),
    .flag_ovf(flag_ovf), .lvl_thr(lvl_thr)
);

// File: tb/sim_ir_pulse_capture.sv
// Bench: random frames plus directed corners against a bench-side model.
module sim_ir_pulse_capture;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;
    localparam int INIT       = 8;

    localparam logic [5:0] R_EN = 6'h00, R_CFG = 6'h04, R_BUSY = 6'h08,
                           R_START = 6'h0C, R_CNT = 6'h10, R_DATA = 6'h14,
                           R_MASK = 6'h18, R_STAT = 6'h1C, R_CLR = 6'h20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ir_in = 1'b0;
    logic [5:0] bus_addr = '0;
    logic bus_wr = 1'b0;
    logic bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic irq_rx, irq_tmo, irq_ovf;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q [DEPTH];
    int  exp_n = 0;
    int  lvl = 2;
    bit  e_rx = 0, e_tmo = 0, e_ovf = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ir_pulse_capture #(.FIFO_DEPTH(DEPTH), .INIT_CYCLES(INIT)) u0 (
        .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_rx(irq_rx), .irq_tmo(irq_tmo),
        .irq_ovf(irq_ovf)
    );

    function automatic logic [31:0] stat_word(bit rx, bit tmo, bit ovf);
        logic [31:0] v = '0;
        v[8] = rx;  v[9] = tmo;  v[10] = ovf;
        v[24] = rx; v[25] = tmo; v[26] = ovf;
        return v;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic hold(bit lv, int cycles);
        ir_in = lv;
        repeat (cycles) @(negedge clk);
    endtask

    task automatic model_push(logic [31:0] w, bit is_tmo);
        if (exp_n < DEPTH) begin
            exp_q[exp_n] = w;
            exp_n++;
            if (exp_n >= lvl + 1) e_rx = 1;
        end else begin
            e_ovf = 1;
        end
        if (is_tmo) e_tmo = 1;
    endtask

    // Frame of n symbols, widths 1..kmax units plus half a unit; last times out.
    task automatic send_frame(int n, int p, int maxw, int kmax);
        int u = 10 * (p + 1);
        hold(1'b0, 2 * u);
        for (int i = 0; i < n; i++) begin
            int k1 = $urandom_range(kmax, 1);
            hold(1'b1, k1 * u + u / 2);
            if (i < n - 1) begin
                int k2 = $urandom_range(kmax, 1);
                hold(1'b0, k2 * u + u / 2);
                model_push({16'(k2), 16'(k1)}, 1'b0);
            end else begin
                hold(1'b0, (maxw + 2) * u);
                model_push({16'(maxw - k1), 16'(k1)}, 1'b1);
            end
        end
    endtask

    task automatic drain_and_check(string req);
        logic [31:0] d;
        rd(R_CNT, d);
        check({req, " R6 count"}, d, 32'(exp_n));
        for (int i = 0; i < exp_n; i++) begin
            rd(R_DATA, d);
            check({req, " R3 R4 word"}, d, exp_q[i]);
        end
        exp_n = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int p;
        int n;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(R_BUSY, d); check("R1 busy", d, 0);
        rd(R_CNT, d);  check("R1 count", d, 0);
        rd(R_STAT, d); check("R1 status", d, 0);
        rd(R_CFG, d);  check("R1 config", d, 32'h3E80_0080);
        rd(R_MASK, d); check("R1 mask", d, 7);
        check("R1 R10 irq", {29'd0, irq_ovf, irq_tmo, irq_rx}, 0);

        // R2: no capture before enable/start
        hold(1'b1, 40); hold(1'b0, 200);
        wr(R_EN, 1);
        rd(R_BUSY, d); check("R2 busy after enable", d, 1);
        wr(R_START, 1);
        repeat (INIT + 2) @(negedge clk);
        rd(R_BUSY, d); check("R2 busy released", d, 0);
        hold(1'b1, 40); hold(1'b0, 200);
        rd(R_CNT, d); check("R2 start while busy ignored", d, 0);
        wr(R_START, 0);
        wr(R_MASK, 0);

        // Random frames with varying prescaler
        for (int r = 0; r < 4; r++) begin
            p = $urandom_range(2, 0);
            n = (r == 0) ? 2 : $urandom_range(6, 3);
            wr(R_CFG, {16'd20, 2'b00, 6'(lvl), 1'b1, 7'(p)});
            send_frame(n, p, 20, 6);
            rd(R_STAT, d); check("R5 R7 R9 status", d, stat_word(e_rx, e_tmo, e_ovf));
            check("R10 irq_tmo unmasked", {31'd0, irq_tmo}, 1);
            check("R10 irq_rx", {31'd0, irq_rx}, {31'd0, e_rx});
            if (r == 1) begin
                wr(R_MASK, 3'b010);
                check("R10 irq_tmo masked", {31'd0, irq_tmo}, 0);
                rd(R_STAT, d); check("R10 flag kept under mask", d[9], 1);
                wr(R_MASK, 0);
            end
            drain_and_check("frame");
            wr(R_CLR, 32'h0);
            rd(R_STAT, d); check("R9 zero clear no effect", d, stat_word(e_rx, e_tmo, e_ovf));
            wr(R_CLR, 32'h0007_0000);
            e_rx = 0; e_tmo = 0; e_ovf = 0;
            rd(R_STAT, d); check("R9 cleared", d, 0);
        end

        // R6: empty read
        rd(R_DATA, d); check("R6 empty read", d, 0);
        rd(R_CNT, d);  check("R6 count after empty read", d, 0);

        // R8: overflow keeps contents
        wr(R_CFG, {16'd20, 2'b00, 6'(lvl), 1'b1, 7'd0});
        send_frame(70, 0, 20, 2);
        rd(R_STAT, d); check("R8 overflow status", d, stat_word(e_rx, e_tmo, e_ovf));
        check("R8 R10 irq_ovf", {31'd0, irq_ovf}, 1);
        drain_and_check("R8 overflow");
        rd(R_STAT, d); check("R8 flag survives drain", d[10], 1);
        wr(R_CLR, 32'h0004_0000);
        rd(R_STAT, d); check("R9 ovf clear only", d, stat_word(1, 1, 0));

        // R2: re-enable flushes flags
        wr(R_EN, 1);
        rd(R_STAT, d); check("R2 enable clears flags", d, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule